// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Station Address Filter

This block receives asynchronous serial frames on one line and hands each accepted frame to software as a byte, a ninth bit and an interrupt flag. In the nine-bit modes a frame is a low start bit, eight data bits sent least significant first, a ninth bit and a high stop bit. In the eight-bit modes the ninth bit is left out. The line is sampled on a clock-enable tick that runs at sixteen times the bit rate. Each bit is decided by a majority of three samples taken near the bit centre.

On a multidrop link, a station sets the filter flag and waits for an address frame. An address frame has its ninth bit at 1. The receiver compares the received byte with the station address held in a register. Frames that do not match are dropped without disturbing software. Once its own address has been flagged, software clears the filter flag and receives the data frames that follow. When the message is complete, software sets the flag again.

Top module: `ninebit_addr_rx`

## Requirements
- R1: After reset, rxIrq, rxNinth, rxData and ctlState are all 0, the station address is 0 and the receiver waits for a start bit.
- R2: Control writes set ctlState from ctlWdata. Bits 1:0 select the mode: values 10 and 11 are the nine-bit modes, 00 and 01 the eight-bit modes. Bit 2 is the receive enable and bit 3 is the filter flag. A valid frame places data bit k (k = 0 is sent first) at rxData[k].
- R3: In a nine-bit mode with the filter flag at 0, every valid frame loads rxData and rxNinth and sets rxIrq, for a ninth bit of either 0 or 1.
- R4: In a nine-bit mode with the filter flag at 1, a frame sets rxIrq only if its ninth bit is 1 and its byte equals the station address. Any other frame leaves rxData, rxNinth and rxIrq unchanged.
- R5: In an eight-bit mode the filter flag has no effect. Every valid frame is accepted, and rxNinth takes the value of the stop bit, which is 1.
- R6: While the receive enable is 0, no frame is captured and rxIrq is not raised.
- R7: A falling edge counts as a start bit only if the start-bit vote comes out low. Otherwise the receiver returns to idle and waits for the next falling edge.
- R8: Each bit takes the majority of samples taken on ticks 7, 8 and 9 of its 16 ticks, so a single wrong sample does not change the bit.
- R9: A frame whose stop bit is voted low is discarded. rxData, rxNinth and rxIrq keep their values.
- R10: If rxIrq is still set when a frame completes, that frame is dropped and the held rxData and rxNinth are kept.
- R11: rxIrq stays set until software pulses irqClear, and the pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | Clock enable at sixteen times the bit rate |
| rxLine | input | 1 | Serial input line, idle high |
| ctlWrite | input | 1 | Write strobe for the control register |
| ctlWdata | input | 4 | Control value: mode[1:0], enable[2], filter[3] |
| addrWrite | input | 1 | Write strobe for the station address |
| addrWdata | input | 8 | Station address value |
| irqClear | input | 1 | Clears the receive interrupt flag |
| ctlState | output | 4 | Current control register contents |
| rxData | output | 8 | Last accepted byte |
| rxNinth | output | 1 | Last accepted ninth bit |
| rxIrq | output | 1 | Receive interrupt flag |

## Verification
A wrong bit-slot counter or a wrong bit index shows up as a shifted or corrupted rxData about one frame time after the fault, because every frame passes through the same slots. An error in the address compare or the filter gating shows within the same frame. In that case rxIrq either rises for a foreign address or stays low for the station's own address, which the filter tests expose. A sampler that has lost bit alignment after a bad stop bit or a false start shows at the next good frame, so each of those tests is followed by a recovery frame whose byte is checked.

// File: rtl/ninebit_rx_pkg.sv
package ninebit_rx_pkg;

  localparam int BYTE_W  = 8;
  localparam int FRAME_W = BYTE_W + 1;
  localparam int IDX_W   = $clog2(FRAME_W + 1);
  localparam int CTL_W   = 4;

  // control register field positions
  localparam int CTL_MODE_LO = 0;
  localparam int CTL_MODE_HI = 1;   // 1 selects a nine-bit mode
  localparam int CTL_ENABLE  = 2;
  localparam int CTL_FILTER  = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic             takeSample;  // shift the line into the vote window
    logic             storeBit;    // write the voted bit into the frame slot
    logic [IDX_W-1:0] bitIdx;      // frame slot of the current data bit
    logic             frameEnd;    // stop bit voted, evaluate the frame
  } rxStrobe_t;

endpackage

// File: rtl/ninebit_rx_ctrl.sv
module ninebit_rx_ctrl
  import ninebit_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      lineLow,
  input  logic      voteBit,
  input  logic      rxEn,
  input  logic      nineMode,
  output rxStrobe_t strobe
);

  localparam int CNT_W      = $clog2(OVS);
  localparam int MID        = OVS / 2;
  localparam int SAMP_FIRST = MID - 1;
  localparam int SAMP_LAST  = MID + 1;
  localparam int DECIDE     = MID + 2;
  localparam int LAST_TICK  = OVS - 1;

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             inWindow;
  logic             atDecide;
  logic             atLast;

  assign lastIdx  = nineMode ? IDX_W'(FRAME_W - 1) : IDX_W'(BYTE_W - 1);
  assign inWindow = (tickCnt >= CNT_W'(SAMP_FIRST)) && (tickCnt <= CNT_W'(SAMP_LAST));
  assign atDecide = (tickCnt == CNT_W'(DECIDE));
  assign atLast   = (tickCnt == CNT_W'(LAST_TICK));

  always_comb begin
    strobe            = '0;
    strobe.bitIdx     = bitIdx;
    strobe.takeSample = baudTick && (state != ST_IDLE) && inWindow;
    strobe.storeBit   = baudTick && (state == ST_DATA) && atLast;
    strobe.frameEnd   = baudTick && (state == ST_STOP) && atDecide;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (baudTick) begin
      case (state)
        ST_IDLE: begin
          if (rxEn && lineLow) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (atDecide && voteBit) begin
            state <= ST_IDLE;
          end else if (atLast) begin
            state   <= ST_DATA;
            tickCnt <= '0;
            bitIdx  <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (atLast) begin
            tickCnt <= '0;
            if (bitIdx == lastIdx) begin
              state <= ST_STOP;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (atDecide) begin
            state <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ninebit_rx_dp.sv
module ninebit_rx_dp
  import ninebit_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              ctlWrite,
  input  logic [CTL_W-1:0]  ctlWdata,
  input  logic              addrWrite,
  input  logic [BYTE_W-1:0] addrWdata,
  input  logic              irqClear,
  input  rxStrobe_t         strobe,
  output logic              lineLow,
  output logic              voteBit,
  output logic              rxEn,
  output logic              nineMode,
  output logic [CTL_W-1:0]  ctlState,
  output logic [BYTE_W-1:0] stationAddr,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxNinth,
  output logic              rxIrq
);

  logic [1:0]         syncQ;
  logic [2:0]         voteQ;
  logic [FRAME_W-1:0] frameQ;
  logic [CTL_W-1:0]   ctlQ;
  logic               filterOn;
  logic               gotNinth;
  logic               addrHit;
  logic               passFilter;
  logic               accept;

  assign lineLow  = !syncQ[1];
  assign voteBit  = (voteQ[0] & voteQ[1]) | (voteQ[1] & voteQ[2]) | (voteQ[0] & voteQ[2]);
  assign ctlState = ctlQ;
  assign rxEn     = ctlQ[CTL_ENABLE];
  assign nineMode = ctlQ[CTL_MODE_HI];
  assign filterOn = ctlQ[CTL_FILTER];

  // eight-bit modes take the stop bit as the ninth bit
  assign gotNinth   = nineMode ? frameQ[BYTE_W] : voteBit;
  assign addrHit    = gotNinth && (frameQ[BYTE_W-1:0] == stationAddr);
  assign passFilter = !(nineMode && filterOn) || addrHit;
  assign accept     = strobe.frameEnd && voteBit && rxEn
                      && (!rxIrq || irqClear) && passFilter;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= 2'b11;
      voteQ <= 3'b111;
    end else begin
      syncQ <= {syncQ[0], rxLine};
      if (strobe.takeSample) begin
        voteQ <= {voteQ[1:0], syncQ[1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '0;
    end else if (strobe.storeBit && (strobe.bitIdx < IDX_W'(FRAME_W))) begin
      frameQ[strobe.bitIdx] <= voteBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ        <= '0;
      stationAddr <= '0;
    end else begin
      if (ctlWrite) begin
        ctlQ <= ctlWdata;
      end
      if (addrWrite) begin
        stationAddr <= addrWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxNinth <= 1'b0;
      rxIrq   <= 1'b0;
    end else if (accept) begin
      rxData  <= frameQ[BYTE_W-1:0];
      rxNinth <= gotNinth;
      rxIrq   <= 1'b1;
    end else if (irqClear) begin
      rxIrq <= 1'b0;
    end
  end

endmodule

// File: rtl/ninebit_addr_rx.sv
module ninebit_addr_rx
  import ninebit_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              rxLine,
  input  logic              ctlWrite,
  input  logic [CTL_W-1:0]  ctlWdata,
  input  logic              addrWrite,
  input  logic [BYTE_W-1:0] addrWdata,
  input  logic              irqClear,
  output logic [CTL_W-1:0]  ctlState,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxNinth,
  output logic              rxIrq
);

  rxStrobe_t         strobe;
  logic              lineLow;
  logic              voteBit;
  logic              rxEn;
  logic              nineMode;
  logic [BYTE_W-1:0] stationAddr;

  ninebit_rx_ctrl #(.OVS(OVS)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .lineLow  (lineLow),
    .voteBit  (voteBit),
    .rxEn     (rxEn),
    .nineMode (nineMode),
    .strobe   (strobe)
  );

  ninebit_rx_dp dp (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .ctlWrite    (ctlWrite),
    .ctlWdata    (ctlWdata),
    .addrWrite   (addrWrite),
    .addrWdata   (addrWdata),
    .irqClear    (irqClear),
    .strobe      (strobe),
    .lineLow     (lineLow),
    .voteBit     (voteBit),
    .rxEn        (rxEn),
    .nineMode    (nineMode),
    .ctlState    (ctlState),
    .stationAddr (stationAddr),
    .rxData      (rxData),
    .rxNinth     (rxNinth),
    .rxIrq       (rxIrq)
  );

endmodule

// File: rtl/ninebit_rx_checker.sv
module ninebit_rx_checker
  import ninebit_rx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              irqClear,
  input logic              rxIrq,
  input logic              rxNinth,
  input logic [BYTE_W-1:0] rxData,
  input logic [CTL_W-1:0]  ctlState,
  input logic [BYTE_W-1:0] stationAddr
);

  // R11: the flag is sticky until software clears it
  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq && !irqClear |=> rxIrq);

  // R10: a pending flag protects the held frame
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq && !irqClear |=> $stable(rxData) && $stable(rxNinth));

  // R6: no flag while reception is disabled
  a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) |-> $past(ctlState[CTL_ENABLE]));

  // R4: with filtering in a nine-bit mode only the own address is flagged
  a_r4_address_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) && $past(ctlState[CTL_FILTER]) && $past(ctlState[CTL_MODE_HI])
    |-> rxNinth && (rxData == $past(stationAddr)));

  // R5: eight-bit modes report the stop bit as the ninth bit
  a_r5_eight_bit_ninth: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) && !$past(ctlState[CTL_MODE_HI]) |-> rxNinth);

endmodule

bind ninebit_addr_rx ninebit_rx_checker chk (
  .clk         (clk),
  .rstN        (rstN),
  .irqClear    (irqClear),
  .rxIrq       (rxIrq),
  .rxNinth     (rxNinth),
  .rxData      (rxData),
  .ctlState    (ctlState),
  .stationAddr (stationAddr)
);

// File: tb/ninebit_addr_rx_test.sv
module ninebit_addr_rx_test;

  localparam int TICK_DIV = 4;
  localparam int BIT_CYC  = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       ctlWrite = 1'b0;
  logic [3:0] ctlWdata = '0;
  logic       addrWrite = 1'b0;
  logic [7:0] addrWdata = '0;
  logic       irqClear = 1'b0;
  logic [3:0] ctlState;
  logic [7:0] rxData;
  logic       rxNinth;
  logic       rxIrq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  ninebit_addr_rx uut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxLine(rxLine),
    .ctlWrite(ctlWrite), .ctlWdata(ctlWdata), .addrWrite(addrWrite),
    .addrWdata(addrWdata), .irqClear(irqClear), .ctlState(ctlState),
    .rxData(rxData), .rxNinth(rxNinth), .rxIrq(rxIrq)
  );

  always #5 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % TICK_DIV;
      baudTick = (div == 0);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCtl(input logic [3:0] v);
    @(negedge clk); ctlWrite = 1'b1; ctlWdata = v;
    @(negedge clk); ctlWrite = 1'b0;
  endtask

  task automatic setAddr(input logic [7:0] a);
    @(negedge clk); addrWrite = 1'b1; addrWdata = a;
    @(negedge clk); addrWrite = 1'b0;
  endtask

  task automatic clearIrq();
    @(negedge clk); irqClear = 1'b1;
    @(negedge clk); irqClear = 1'b0;
  endtask

  // one bit slot, optionally with a one-tick glitch in its centre
  task automatic holdBit(input logic v, input bit glitch);
    for (int c = 0; c < BIT_CYC; c++) begin
      rxLine = (glitch && c >= 8 * TICK_DIV && c < 9 * TICK_DIV) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic ninth, input bit nine,
                           input logic stopV, input int glitchIdx);
    @(negedge clk);
    holdBit(1'b0, 1'b0);
    for (int k = 0; k < 8; k++) holdBit(b[k], glitchIdx == k);
    if (nine) holdBit(ninth, 1'b0);
    holdBit(stopV, 1'b0);
    rxLine = 1'b1;
    idle(40);
  endtask

  task automatic t_reset();
    check("R1 irq", rxIrq, 0);
    check("R1 ninth", rxNinth, 0);
    check("R1 data", rxData, 0);
    check("R1 ctl", ctlState, 0);
  endtask

  task automatic t_nine_open();
    setCtl(4'b0110);
    check("R2 ctl write", ctlState, 4'b0110);
    sendFrame(8'hA5, 1'b0, 1, 1'b1, -1);
    check("R2 R3 data ninth0", rxData, 8'hA5);
    check("R3 ninth0", rxNinth, 0);
    check("R3 irq ninth0", rxIrq, 1);
    clearIrq();
    check("R11 cleared", rxIrq, 0);
    sendFrame(8'h3C, 1'b1, 1, 1'b1, -1);
    check("R3 data ninth1", rxData, 8'h3C);
    check("R3 ninth1", rxNinth, 1);
    check("R3 irq ninth1", rxIrq, 1);
    clearIrq();
  endtask

  task automatic t_filter();
    setAddr(8'h5A);
    setCtl(4'b1111);
    sendFrame(8'h5A, 1'b0, 1, 1'b1, -1);
    check("R4 data frame ignored irq", rxIrq, 0);
    check("R4 data frame ignored data", rxData, 8'h3C);
    sendFrame(8'h33, 1'b1, 1, 1'b1, -1);
    check("R4 foreign address irq", rxIrq, 0);
    check("R4 foreign address data", rxData, 8'h3C);
    sendFrame(8'h5A, 1'b1, 1, 1'b1, -1);
    check("R4 own address irq", rxIrq, 1);
    check("R4 own address data", rxData, 8'h5A);
    check("R4 own address ninth", rxNinth, 1);
    clearIrq();
    setCtl(4'b0111);
    sendFrame(8'h77, 1'b0, 1, 1'b1, -1);
    check("R4 payload after address", rxData, 8'h77);
    check("R4 payload irq", rxIrq, 1);
    clearIrq();
    setCtl(4'b1111);
    sendFrame(8'h11, 1'b0, 1, 1'b1, -1);
    check("R4 refiltered irq", rxIrq, 0);
    check("R4 refiltered data", rxData, 8'h77);
  endtask

  task automatic t_eight();
    setCtl(4'b1101);
    sendFrame(8'hC3, 1'b0, 0, 1'b1, -1);
    check("R5 eight-bit data", rxData, 8'hC3);
    check("R5 eight-bit ninth", rxNinth, 1);
    check("R5 eight-bit irq", rxIrq, 1);
    clearIrq();
  endtask

  task automatic t_disabled();
    setCtl(4'b0010);
    sendFrame(8'h99, 1'b1, 1, 1'b1, -1);
    check("R6 disabled irq", rxIrq, 0);
    check("R6 disabled data", rxData, 8'hC3);
  endtask

  task automatic t_false_start();
    setCtl(4'b0110);
    @(negedge clk);
    rxLine = 1'b0;
    idle(3 * TICK_DIV);
    rxLine = 1'b1;
    idle(2 * BIT_CYC);
    check("R7 glitch irq", rxIrq, 0);
    check("R7 glitch data", rxData, 8'hC3);
    sendFrame(8'h42, 1'b0, 1, 1'b1, -1);
    check("R7 recovery data", rxData, 8'h42);
    clearIrq();
  endtask

  task automatic t_vote();
    sendFrame(8'hF0, 1'b0, 1, 1'b1, 0);
    check("R8 glitch low bit", rxData, 8'hF0);
    clearIrq();
    sendFrame(8'hF0, 1'b0, 1, 1'b1, 5);
    check("R8 glitch high bit", rxData, 8'hF0);
    clearIrq();
  endtask

  task automatic t_bad_stop();
    sendFrame(8'h81, 1'b1, 1, 1'b0, -1);
    idle(2 * BIT_CYC);
    check("R9 bad stop irq", rxIrq, 0);
    check("R9 bad stop data", rxData, 8'hF0);
    check("R9 bad stop ninth", rxNinth, 0);
    sendFrame(8'h18, 1'b1, 1, 1'b1, -1);
    check("R9 recovery data", rxData, 8'h18);
    clearIrq();
  endtask

  task automatic t_overrun();
    sendFrame(8'h55, 1'b0, 1, 1'b1, -1);
    check("R10 first frame", rxData, 8'h55);
    sendFrame(8'hAA, 1'b1, 1, 1'b1, -1);
    check("R10 held data", rxData, 8'h55);
    check("R10 held ninth", rxNinth, 0);
    check("R10 irq kept", rxIrq, 1);
    clearIrq();
    check("R11 clear after overrun", rxIrq, 0);
  endtask

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(5);
    t_reset();
    t_nine_open();
    t_filter();
    t_eight();
    t_disabled();
    t_false_start();
    t_vote();
    t_bad_stop();
    t_overrun();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule